// File: doc/BRIEF.md
# Fast-Path Frame Classifier

This block watches a received frame as a stream of 32-bit words and, with a fixed set of word-offset comparisons, sends each frame to one of three destinations. A frame bound for the fast data path is recognised only from the UDP destination port and from the first payload word. An address-recovery frame carries a private ethertype and a four-character tag, and it delivers a new device IP address. Every other frame goes to the slow-path processor together with its length. No other header field is validated, so the block needs no storage for the frame. It keeps a few match flags and a captured address word.

Word 0 is the first word of a frame, marked by the start flag, and its bytes are packed most significant byte first. Two pad bytes come first, so the ethertype lands in the low half of word 3 and the UDP destination port in the low half of word 9. The recovery tag fills word 4, the recovered address fills word 5, and word 11 is the first payload word. The controller has four states. IDLE means no frame is open. SCAN means a frame is open and undecided. HOLD means a frame is open and its route is decided. CLOSE is the single cycle after the end-of-frame word.

The transitions are as follows. A start word moves any state to SCAN, or to CLOSE if the same word also ends the frame. SCAN goes to CLOSE on an end word, and to HOLD on word 11 when that word does not end the frame. HOLD goes to CLOSE on the end word. CLOSE returns to IDLE unless a new start word arrives.

Top module: `fp_frame_classifier`

## Requirements
- R1: While reset is held and after reset is released, route_valid, ip_set_stb and slow_stb are 0.
- R2: The route is FAST (code 1) when word 9 bits [15:0] equal cfg_data_port and word 11 differs from the invalid-header value (default 0). This route is visible from the cycle after word 11 is accepted.
- R3: When word 11 equals the invalid-header value, the frame is never FAST, even if the port matches.
- R4: The route is RECOVER (code 2) when it is not FAST, word 3 bits [15:0] equal 0xBEEE, word 4 equals 0x61646472 ("addr") and word 5 has arrived. In the decision cycle, ip_set_stb pulses for one cycle with ip_set_value equal to word 5. The strobe never pulses for any other route.
- R5: When a frame meets both the FAST and the RECOVER conditions, the route is FAST and ip_set_stb stays 0.
- R6: A frame of at least 12 words that is neither FAST nor RECOVER has route SLOW (code 3), decided in the cycle after word 11.
- R7: For a SLOW frame, slow_stb pulses in the cycle after the end word. In that cycle slow_len equals the index of the last word minus 3, saturated at 0.
- R8: A frame that ends before word 11 is decided in the cycle after its end word. Its route is RECOVER if it meets the R4 conditions and SLOW otherwise.
- R9: route_valid rises in the decision cycle, and route stays constant through the cycle after the end word. route_valid falls on the next cycle unless that cycle's word opens a frame that is decided at once.
- R10: Words other than 3, 4, 5, 9 and 11 do not change the route. A valid word without the start flag while no frame is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word present this cycle |
| in_sof | input | 1 | Word is word 0 of a frame |
| in_eof | input | 1 | Word is the last of a frame |
| in_data | input | 32 | Frame word, first byte in bits [31:24] |
| cfg_data_port | input | 16 | UDP port that marks fast-path frames |
| route_valid | output | 1 | Route decided for the current frame |
| route | output | 2 | 1 FAST, 2 RECOVER, 3 SLOW |
| ip_set_stb | output | 1 | One-cycle pulse: load new device IP |
| ip_set_value | output | 32 | Recovered IP address |
| slow_stb | output | 1 | One-cycle pulse: slow-path frame complete |
| slow_len | output | IDX_W | Slow-path length in words |

## Verification
The bench sweeps frame lengths from 1 to 16 words. For each length it tries every combination of four conditions: a matching port, an invalid first payload word, the recovery ethertype and the recovery tag. It repeats the sweep with two different filler patterns in the unchecked words. Frames that end before word 11 separate the early-decision rule from the word-11 rule. Frames that are both FAST and RECOVER separate the priority order from the recovery path. Alternating frames run back to back or are followed by a stray non-start word, which shows that the held route ends on time and that idle words are ignored.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int WORD_W = 32;

    // Word positions fixed by the frame layout (2 pad bytes, Ethernet, IPv4, UDP)
    localparam int W_ETYPE  = 3;
    localparam int W_TAG    = 4;
    localparam int W_IP     = 5;
    localparam int W_PORT   = 9;
    localparam int W_STREAM = 11;

    localparam logic [15:0]       RECOV_ETYPE = 16'hBEEE;
    localparam logic [WORD_W-1:0] RECOV_TAG   = 32'h6164_6472;

    typedef enum logic [1:0] {
        RT_NONE    = 2'd0,
        RT_FAST    = 2'd1,
        RT_RECOVER = 2'd2,
        RT_SLOW    = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_HOLD,
        ST_CLOSE
    } state_e;

endpackage

// File: rtl/fpc_word_counter.sv
module fpc_word_counter #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             sof,
    output logic [IDX_W-1:0] cur_idx
);

    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] cnt_q;

    assign cur_idx = sof ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= (cur_idx == IDX_MAX) ? cur_idx : cur_idx + 1'b1;
        end
    end

endmodule

// File: rtl/fpc_field_capture.sv
module fpc_field_capture
    import fpc_pkg::*;
#(
    parameter int                IDX_W       = 8,
    parameter logic [WORD_W-1:0] INVALID_HDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] data,
    input  logic [15:0]       cfg_port,
    output logic              fast_hit,
    output logic              recov_hit,
    output logic [WORD_W-1:0] ip_now
);

    localparam logic [IDX_W-1:0] IX_ETYPE = IDX_W'(W_ETYPE);
    localparam logic [IDX_W-1:0] IX_TAG   = IDX_W'(W_TAG);
    localparam logic [IDX_W-1:0] IX_IP    = IDX_W'(W_IP);
    localparam logic [IDX_W-1:0] IX_PORT  = IDX_W'(W_PORT);

    logic              etype_q;
    logic              tag_q;
    logic              port_q;
    logic [WORD_W-1:0] ip_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            etype_q <= 1'b0;
            tag_q   <= 1'b0;
            port_q  <= 1'b0;
            ip_q    <= '0;
        end else if (accept) begin
            if (idx == '0) begin
                etype_q <= 1'b0;
                tag_q   <= 1'b0;
                port_q  <= 1'b0;
            end
            if (idx == IX_ETYPE) etype_q <= (data[15:0] == RECOV_ETYPE);
            if (idx == IX_TAG)   tag_q   <= (data == RECOV_TAG);
            if (idx == IX_IP)    ip_q    <= data;
            if (idx == IX_PORT)  port_q  <= (data[15:0] == cfg_port);
        end
    end

    // Meaningful when idx is the stream-header word
    assign fast_hit  = port_q && (data != INVALID_HDR);
    // Address word must have arrived (this cycle or earlier)
    assign recov_hit = etype_q && tag_q && (idx >= IX_IP);
    assign ip_now    = (idx == IX_IP) ? data : ip_q;

endmodule

// File: rtl/fp_frame_classifier.sv
module fp_frame_classifier
    import fpc_pkg::*;
#(
    parameter int                IDX_W       = 8,
    parameter logic [WORD_W-1:0] INVALID_HDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [WORD_W-1:0] in_data,
    input  logic [15:0]       cfg_data_port,
    output logic              route_valid,
    output logic [1:0]        route,
    output logic              ip_set_stb,
    output logic [WORD_W-1:0] ip_set_value,
    output logic              slow_stb,
    output logic [IDX_W-1:0]  slow_len
);

    localparam logic [IDX_W-1:0] IX_STREAM = IDX_W'(W_STREAM);
    localparam logic [IDX_W-1:0] LEN_BIAS  = IDX_W'(3);

    state_e            state_q, state_d;
    route_e            route_q, route_calc, route_eff;
    logic              accept, decide_now;
    logic [IDX_W-1:0]  cur_idx;
    logic              fast_hit, recov_hit;
    logic [WORD_W-1:0] ip_now;

    assign accept = in_valid && (in_sof || state_q == ST_SCAN || state_q == ST_HOLD);

    fpc_word_counter #(.IDX_W(IDX_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .sof     (in_sof),
        .cur_idx (cur_idx)
    );

    fpc_field_capture #(.IDX_W(IDX_W), .INVALID_HDR(INVALID_HDR)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .idx       (cur_idx),
        .data      (in_data),
        .cfg_port  (cfg_data_port),
        .fast_hit  (fast_hit),
        .recov_hit (recov_hit),
        .ip_now    (ip_now)
    );

    assign decide_now = accept && (in_sof || state_q == ST_SCAN)
                        && (in_eof || cur_idx == IX_STREAM);

    always_comb begin
        if (cur_idx == IX_STREAM && fast_hit) route_calc = RT_FAST;
        else if (recov_hit)                   route_calc = RT_RECOVER;
        else                                  route_calc = RT_SLOW;
        route_eff = decide_now ? route_calc : route_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (accept && in_sof) begin
            state_d = in_eof ? ST_CLOSE : ST_SCAN;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_SCAN: begin
                    if (accept && in_eof)                  state_d = ST_CLOSE;
                    else if (accept && cur_idx == IX_STREAM) state_d = ST_HOLD;
                end
                ST_HOLD: begin
                    if (accept && in_eof) state_d = ST_CLOSE;
                end
                ST_CLOSE: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q      <= RT_NONE;
            ip_set_stb   <= 1'b0;
            ip_set_value <= '0;
            slow_stb     <= 1'b0;
            slow_len     <= '0;
        end else begin
            ip_set_stb <= 1'b0;
            slow_stb   <= 1'b0;
            if (state_d == ST_IDLE || (accept && in_sof)) route_q <= RT_NONE;
            if (decide_now) begin
                route_q <= route_calc;
                if (route_calc == RT_RECOVER) begin
                    ip_set_stb   <= 1'b1;
                    ip_set_value <= ip_now;
                end
            end
            if (accept && in_eof && route_eff == RT_SLOW) begin
                slow_stb <= 1'b1;
                slow_len <= (cur_idx >= LEN_BIAS) ? cur_idx - LEN_BIAS : '0;
            end
        end
    end

    assign route_valid = (state_q == ST_HOLD) || (state_q == ST_CLOSE);
    assign route       = route_q;

    // R9: a decided route never reads as "none"
    a_r9_valid_has_route: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> route_q != RT_NONE);

    // R9: route held while the frame stays open
    a_r9_route_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !(in_valid && in_sof)) |=> $stable(route_q));

    // R4: address strobe only for recovery frames, single cycle
    a_r4_ip_only_recover: assert property (@(posedge clk) disable iff (!rst_n)
        ip_set_stb |-> (route_q == RT_RECOVER && route_valid));

    a_r4_ip_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ip_set_stb |=> !ip_set_stb);

    // R7: slow-path strobe only in the closing cycle of a slow frame
    a_r7_slow_in_close: assert property (@(posedge clk) disable iff (!rst_n)
        slow_stb |-> (state_q == ST_CLOSE && route_q == RT_SLOW));

endmodule

// File: tb/sim_fp_frame_classifier.sv
`timescale 1ns/1ps
module sim_fp_frame_classifier;

    localparam int IDX_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [31:0]      in_data = '0;
    logic [15:0]      cfg_data_port = 16'h07D1;
    logic             route_valid, ip_set_stb, slow_stb;
    logic [1:0]       route;
    logic [31:0]      ip_set_value;
    logic [IDX_W-1:0] slow_len;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    fp_frame_classifier #(.IDX_W(IDX_W)) u0 (
        .clk, .rst_n, .in_valid, .in_sof, .in_eof, .in_data, .cfg_data_port,
        .route_valid, .route, .ip_set_stb, .ip_set_value, .slow_stb, .slow_len
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int k, input int len, input bit pm,
                                           input bit inv, input bit et, input bit tg, input int seed);
        logic [31:0] f;
        f = 32'hA500_0000 ^ (32'(k) * 32'h0101_0101) ^ 32'(seed * 7919);
        case (k)
            3:  return {f[31:16], et ? 16'hBEEE : 16'h0800};
            4:  return tg ? 32'h6164_6472 : 32'h6164_6473;
            5:  return 32'hC0A8_0000 | 32'(len * 16 + seed);
            9:  return {f[31:16], pm ? 16'h07D1 : 16'h07D2};
            11: return inv ? 32'h0 : (32'h1C00_0000 | 32'(k + seed));
            default: return f;
        endcase
    endfunction

    task automatic run_frame(input int len, input bit pm, input bit inv, input bit et,
                             input bit tg, input int seed, input bit gap);
        int d;
        logic [1:0] er;
        string tag;
        d = (len > 11) ? 11 : len - 1;
        if (len >= 12 && pm && !inv)  er = 2'd1;
        else if (et && tg && len >= 6) er = 2'd2;
        else                           er = 2'd3;
        if (er == 2'd1)                     tag = (et && tg) ? "R5" : "R2";
        else if (pm && inv && len >= 12)    tag = "R3";
        else if (len < 12)                  tag = "R8";
        else if (er == 2'd2)                tag = "R4";
        else                                tag = "R6";
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1;
            in_sof   = (k == 0);
            in_eof   = (k == len - 1);
            in_data  = word_of(k, len, pm, inv, et, tg, seed);
            @(posedge clk);
            @(negedge clk);
            chk("R9", "route_valid", 32'(route_valid), 32'(k >= d));
            if (k >= d) chk(tag, "route", 32'(route), 32'(er));
            chk("R4", "ip_set_stb", 32'(ip_set_stb), 32'((k == d) && er == 2'd2));
            if (k == d && er == 2'd2)
                chk("R4", "ip_set_value", ip_set_value, 32'hC0A8_0000 | 32'(len * 16 + seed));
            chk("R7", "slow_stb", 32'(slow_stb), 32'((k == len - 1) && er == 2'd3));
            if (k == len - 1 && er == 2'd3)
                chk("R7", "slow_len", 32'(slow_len), 32'((len >= 4) ? len - 4 : 0));
        end
        in_sof = 1'b0;
        in_eof = 1'b0;
        if (gap) begin
            // R10: stray word without start flag while no frame is open
            in_valid = 1'b1;
            in_data  = 32'hDEAD_0000 | 32'(seed);
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            chk("R10", "route_valid after stray word", 32'(route_valid), 32'd0);
            chk("R10", "ip_set_stb after stray word", 32'(ip_set_stb), 32'd0);
            chk("R10", "slow_stb after stray word", 32'(slow_stb), 32'd0);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "route_valid in reset", 32'(route_valid), 32'd0);
        chk("R1", "ip_set_stb in reset", 32'(ip_set_stb), 32'd0);
        chk("R1", "slow_stb in reset", 32'(slow_stb), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "route_valid after reset", 32'(route_valid), 32'd0);
        chk("R1", "slow_stb after reset", 32'(slow_stb), 32'd0);
        // R10 also: unchecked words differ between the two seeds
        for (int seed = 1; seed <= 2; seed++) begin
            for (int len = 1; len <= 16; len++) begin
                for (int combo = 0; combo < 16; combo++) begin
                    run_frame(len, combo[0], combo[1], combo[2], combo[3], seed,
                              ((len + combo) % 2) == 1);
                end
            end
        end
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "route_valid when idle", 32'(route_valid), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule